// File: doc/BRIEF.md
# Supply-Driven Shadow Store and Recall Sequencer

This block decides when a 2048-byte working RAM is copied into its nonvolatile shadow, and when the shadow is copied back. It makes both decisions from two already-synchronised supply comparator flags. One flag says the supply is under the switch threshold (about 4.0 to 4.5 V). The other says it is under the lower reset threshold (3.6 V). The reset threshold always lies below the switch threshold.

When the supply sags under the switch threshold, host writes are refused at once. The block then checks whether any write has landed since the last store or recall. If so, it waits a short grace window so that a running access can finish, and then runs a store. If not, it does nothing.

A recall is armed at power-up, and again whenever the supply dips under the reset threshold. The armed recall runs once the supply is back above the switch threshold. A shallower brownout leaves the RAM contents alone, and no recall follows it. While a transfer is running, the block raises busy and refuses host reads and writes. The RAM arrays and the copy engine sit outside the block and act on one-cycle start strobes.

Top module: `nvs_seq_top`

## Requirements
- R1: After reset, busy is low and no start strobe is issued. A recall is pending from reset, and it runs as soon as below_switch is low.
- R2: When below_switch rises while the block is idle, and at least one granted write has happened since the last store or recall completed, exactly one store is started.
- R3: When below_switch rises with no granted write since the last completed store or recall, no store is started and busy stays low.
- R4: store_start is asserted DELAY_CYC+1 cycles after the first clock edge that sees below_switch high. Reads are still granted during that grace window.
- R5: busy stays high for exactly STORE_CYC cycles for a store.
- R6: A rise of below_reset arms a recall. The recall starts on the first edge that sees below_switch low, and busy stays high for exactly RESTORE_CYC cycles.
- R7: A brownout in which below_switch rises and falls while below_reset stays low starts no recall.
- R8: wr_grant is low whenever below_switch is high.
- R9: While busy is high, wr_grant and rd_grant are both low.
- R10: The written-since-transfer mark is cleared when a recall completes, so a supply drop with no later write starts no store.
- R11: store_start and recall_start are single-cycle strobes and are never high together. store_start coincides with the first busy cycle of the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| below_switch | input | 1 | Supply under switch threshold |
| below_reset | input | 1 | Supply under reset threshold |
| wr_req | input | 1 | Host asks to write the working RAM |
| rd_req | input | 1 | Host asks to read the working RAM |
| wr_grant | output | 1 | Host write may proceed this cycle |
| rd_grant | output | 1 | Host read may proceed this cycle |
| busy | output | 1 | Store or recall in progress |
| store_start | output | 1 | One-cycle strobe: copy RAM to shadow |
| recall_start | output | 1 | One-cycle strobe: copy shadow to RAM |

## Verification
On every cycle, the checker enforces the following. Writes are refused under the switch threshold, and all access is refused while busy. A store starts only if a granted write has happened since the last transfer ended. The strobes are exclusive, a recall starts only after the supply has come back, and each busy window has the length of its transfer kind. Only the bench scenarios can show the rest. These are the grace-window timing, the absence of any store after a write-free drop, the absence of a recall after a shallow brownout, and the full data round trip: RAM contents written, lost in a deep dip, and restored from the shadow.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    ST_LOW    = 3'd0,
    ST_IDLE   = 3'd1,
    ST_GRACE  = 3'd2,
    ST_STORE  = 3'd3,
    ST_RECALL = 3'd4
  } nvs_state_t;
endpackage

// File: rtl/nvs_timer.sv
module nvs_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/nvs_flag.sv
module nvs_flag #(
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  // set wins over clr
  always_ff @(posedge clk) begin
    if (rst)      q <= RESET_VAL;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/nvs_seq_top.sv
module nvs_seq_top
  import nvs_pkg::*;
#(
  parameter int STORE_CYC   = 40,
  parameter int RESTORE_CYC = 20,
  parameter int DELAY_CYC   = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic below_switch,
  input  logic below_reset,
  input  logic wr_req,
  input  logic rd_req,
  output logic wr_grant,
  output logic rd_grant,
  output logic busy,
  output logic store_start,
  output logic recall_start
);
  localparam int MAXC = (STORE_CYC > RESTORE_CYC) ?
                        ((STORE_CYC > DELAY_CYC) ? STORE_CYC : DELAY_CYC) :
                        ((RESTORE_CYC > DELAY_CYC) ? RESTORE_CYC : DELAY_CYC);
  localparam int CW = $clog2(MAXC + 1) + 1;

  nvs_state_t state, nxt;
  logic          t_load, t_zero;
  logic [CW-1:0] t_val;
  logic          st_go, rc_go, xfer_done;
  logic          dirty, rc_pend;

  nvs_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  nvs_flag #(.RESET_VAL(1'b0)) u_dirty (
    .clk(clk), .rst(rst), .set(wr_grant), .clr(xfer_done), .q(dirty)
  );

  nvs_flag #(.RESET_VAL(1'b1)) u_rc_arm (
    .clk(clk), .rst(rst), .set(below_reset), .clr(rc_go), .q(rc_pend)
  );

  always_comb begin
    nxt       = state;
    t_load    = 1'b0;
    t_val     = '0;
    st_go     = 1'b0;
    rc_go     = 1'b0;
    xfer_done = 1'b0;
    unique case (state)
      ST_LOW: begin
        if (!below_switch) begin
          if (rc_pend) begin
            nxt    = ST_RECALL;
            t_load = 1'b1;
            t_val  = CW'(RESTORE_CYC - 1);
            rc_go  = 1'b1;
          end else begin
            nxt = ST_IDLE;
          end
        end
      end
      ST_IDLE: begin
        if (below_switch) begin
          if (dirty) begin
            nxt    = ST_GRACE;
            t_load = 1'b1;
            t_val  = CW'(DELAY_CYC - 1);
          end else begin
            nxt = ST_LOW;
          end
        end
      end
      ST_GRACE: begin
        if (t_zero) begin
          nxt    = ST_STORE;
          t_load = 1'b1;
          t_val  = CW'(STORE_CYC - 1);
          st_go  = 1'b1;
        end
      end
      ST_STORE, ST_RECALL: begin
        if (t_zero) begin
          nxt       = ST_LOW;
          xfer_done = 1'b1;
        end
      end
      default: nxt = ST_LOW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_LOW;
      busy         <= 1'b0;
      store_start  <= 1'b0;
      recall_start <= 1'b0;
    end else begin
      state        <= nxt;
      busy         <= (nxt == ST_STORE) || (nxt == ST_RECALL);
      store_start  <= st_go;
      recall_start <= rc_go;
    end
  end

  assign wr_grant = wr_req && (state == ST_IDLE) && !below_switch;
  assign rd_grant = rd_req && !busy;
endmodule

// File: rtl/nvs_seq_chk.sv
module nvs_seq_chk #(
  parameter int STORE_CYC   = 40,
  parameter int RESTORE_CYC = 20
) (
  input logic clk,
  input logic rst,
  input logic below_switch,
  input logic wr_grant,
  input logic rd_grant,
  input logic busy,
  input logic store_start,
  input logic recall_start
);
  logic mark;
  logic was_store;
  int   blen;

  always_ff @(posedge clk) begin
    if (rst) begin
      mark      <= 1'b0;
      was_store <= 1'b0;
      blen      <= 0;
    end else begin
      if (wr_grant)           mark <= 1'b1;
      else if (!busy && blen != 0) mark <= 1'b0;
      if (store_start)        was_store <= 1'b1;
      else if (recall_start)  was_store <= 1'b0;
      blen <= busy ? blen + 1 : 0;
    end
  end

  p_no_wr_low_r8: assert property (@(posedge clk) disable iff (rst)
    below_switch |-> !wr_grant);
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!wr_grant && !rd_grant));
  p_store_needs_write_r2: assert property (@(posedge clk) disable iff (rst)
    store_start |-> mark);
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({store_start, recall_start}));
  p_store_busy_r11: assert property (@(posedge clk) disable iff (rst)
    store_start |-> (busy && !$past(busy)));
  p_recall_supply_r6: assert property (@(posedge clk) disable iff (rst)
    recall_start |-> !$past(below_switch));
  p_store_len_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && blen != 0 && was_store) |-> (blen == STORE_CYC));
  p_recall_len_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && blen != 0 && !was_store) |-> (blen == RESTORE_CYC));
endmodule

bind nvs_seq_top nvs_seq_chk #(
  .STORE_CYC(STORE_CYC), .RESTORE_CYC(RESTORE_CYC)
) i_nvs_seq_chk (
  .clk(clk), .rst(rst), .below_switch(below_switch), .wr_grant(wr_grant),
  .rd_grant(rd_grant), .busy(busy), .store_start(store_start),
  .recall_start(recall_start)
);

// File: tb/test_nvs_seq_top.sv
module test_nvs_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int ST  = 40;
  localparam int RS  = 20;
  localparam int DL  = 5;
  localparam int WORDS = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic below_switch = 1'b1, below_reset = 1'b1;
  logic wr_req = 1'b0, rd_req = 1'b0;
  logic wr_grant, rd_grant, busy, store_start, recall_start;
  logic [10:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  ram [WORDS];
  logic [7:0]  shadow [WORDS];
  int total = 0, bad = 0;
  int n_store = 0, n_recall = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvs_seq_top #(.STORE_CYC(ST), .RESTORE_CYC(RS), .DELAY_CYC(DL)) i_nvs_seq_top (
    .clk(clk), .rst(rst), .below_switch(below_switch), .below_reset(below_reset),
    .wr_req(wr_req), .rd_req(rd_req), .wr_grant(wr_grant), .rd_grant(rd_grant),
    .busy(busy), .store_start(store_start), .recall_start(recall_start)
  );

  // memory model: RAM lost in deep dip, copies on strobes
  always @(posedge clk) begin
    if (below_reset) begin
      for (int i = 0; i < WORDS; i++) ram[i] <= 8'h00;
    end else if (recall_start) begin
      for (int i = 0; i < WORDS; i++) ram[i] <= shadow[i];
    end else if (wr_grant) begin
      ram[addr] <= wdata;
    end
    if (store_start) begin
      for (int i = 0; i < WORDS; i++) shadow[i] <= ram[i];
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (store_start)  n_store++;
      if (recall_start) n_recall++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts edges until busy seen high, then busy-high cycles
  task automatic busy_window(output int pre, output int len);
    pre = 0; len = 0;
    while (!busy && pre < 200) begin @(posedge clk); @(negedge clk); pre++; end
    while (busy && len < 200) begin len++; @(posedge clk); @(negedge clk); end
  endtask

  task automatic host_write(input logic [10:0] a, input logic [7:0] d, output bit g);
    @(negedge clk);
    addr = a; wdata = d; wr_req = 1'b1;
    #1 g = wr_grant;
    @(negedge clk);
    wr_req = 1'b0;
  endtask

  task automatic host_read(input logic [10:0] a, output bit g, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_req = 1'b1;
    #1 g = rd_grant; d = ram[a];
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic t_reset();
    int pre, len;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0; below_reset = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(n_store + n_recall == 0, "R1 no strobe while low", n_store + n_recall, 0);
    below_switch = 1'b0;
    busy_window(pre, len);
    chk(pre == 1, "R1 power-up recall start", pre, 1);
    chk(len == RS, "R6 recall length", len, RS);
    chk(n_recall == 1, "R1 one recall", n_recall, 1);
  endtask

  task automatic t_write_store();
    int pre, len; bit g; logic [7:0] d;
    host_write(11'h155, 8'hA5, g);
    chk(g, "R2 write granted idle", g, 1);
    @(negedge clk);
    below_switch = 1'b1; rd_req = 1'b1; wr_req = 1'b1;
    #1;
    chk(!wr_grant, "R8 write refused low", wr_grant, 0);
    chk(rd_grant, "R4 read granted in grace", rd_grant, 1);
    busy_window(pre, len);
    chk(pre == DL + 1, "R4 grace length", pre, DL + 1);
    chk(len == ST, "R5 store length", len, ST);
    chk(n_store == 1, "R2 store issued", n_store, 1);
    wr_req = 1'b0; rd_req = 1'b0;
    host_read(11'h155, g, d);
    chk(d == 8'hA5, "R2 RAM kept", d, 8'hA5);
  endtask

  task automatic t_busy_refuse();
    int len; bit g; logic [7:0] d;
    // deep dip while below switch, then return: recall runs
    @(negedge clk); below_reset = 1'b1;
    @(negedge clk); below_reset = 1'b0;
    below_switch = 1'b0; rd_req = 1'b1; wr_req = 1'b1;
    @(negedge clk);
    chk(busy, "R6 recall after deep dip", busy, 1);
    chk(!rd_grant && !wr_grant, "R9 access refused busy", rd_grant | wr_grant, 0);
    rd_req = 1'b0; wr_req = 1'b0;
    len = 1;
    while (busy && len < 200) begin @(negedge clk); if (busy) len++; end
    chk(len == RS, "R6 recall length", len, RS);
    chk(n_recall == 2, "R6 recall count", n_recall, 2);
    repeat (2) @(negedge clk);
    host_read(11'h155, g, d);
    chk(g && d == 8'hA5, "R6 data restored", d, 8'hA5);
  endtask

  task automatic t_no_write_drop();
    int s0;
    s0 = n_store;
    @(negedge clk); below_switch = 1'b1;
    repeat (DL + ST + 5) begin
      @(negedge clk);
      chk(!busy, "R10 no store after recall", busy, 0);
    end
    chk(n_store == s0, "R10 store count", n_store, s0);
  endtask

  task automatic t_shallow();
    int r0, s0; bit g; logic [7:0] d;
    r0 = n_recall;
    @(negedge clk); below_switch = 1'b0;
    repeat (RS + 5) @(negedge clk);
    chk(n_recall == r0, "R7 no recall after shallow", n_recall, r0);
    chk(!busy, "R7 idle", busy, 0);
    // write, store, then write-free drop: skipped
    host_write(11'h7FF, 8'h3C, g);
    @(negedge clk); below_switch = 1'b1;
    repeat (DL + ST + 4) @(negedge clk);
    below_switch = 1'b0;
    repeat (3) @(negedge clk);
    s0 = n_store;
    below_switch = 1'b1;
    repeat (DL + ST + 5) @(negedge clk);
    chk(n_store == s0, "R3 store skipped", n_store, s0);
    below_switch = 1'b0;
    repeat (3) @(negedge clk);
    host_read(11'h7FF, g, d);
    chk(d == 8'h3C, "R7 RAM intact", d, 8'h3C);
    chk(shadow[11'h7FF] == 8'h3C, "R2 shadow holds", shadow[11'h7FF], 8'h3C);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_write_store();
    t_busy_refuse();
    t_no_write_drop();
    t_shallow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule